// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block sequences a read that a bridge has accepted from an initiator as a delayed transaction and must now complete on the far bus. Once a request is latched, it asks the target-side master to start an attempt. It looks at how each attempt ended and either starts the read again or stops. When it stops, it picks the termination that the bridge will give the initiator once the initiator returns for its data.

There are four ways for the repetition to end. The first is an attempt that moved at least one data phase. The other three are a master abort, a target abort, and a configured number of attempts that all came back without data. On a successful read, the response the initiator sees depends on whether the address space is prefetchable and how much data was obtained compared with how much was asked for. Aborts produce pulses that set status bits on both interfaces. Running out of attempts sets a timeout flag and ends the request with no data.

Top module: `dr_retry_ctrl`

## Requirements
- R1: While reset is held and after it is released, `reinit`, `busy`, `done`, `timeout` and every status pulse are 0, and `resp` is 0 (none).
- R2: When `req_valid` is sampled high while idle, `busy` and `reinit` are high in the next cycle. `reinit` lasts exactly one cycle.
- R3: An attempt reported through `att_done` that does not end the request gets a new `reinit` exactly one cycle after the report, and `done` stays low. Such an attempt is a retry (`att_term` = 1), or a normal completion (0) or target disconnect (2) with `att_xfer` = 0.
- R4: An attempt ending in normal (0) or disconnect (2) with `att_xfer` ≥ 1 ends the request. `done` pulses for one cycle in the cycle after the report, and `busy` is low in that cycle.
- R5: For a prefetchable request (`req_pref` = 1) completing normally, `resp` is disconnect (2) if `att_xfer` < requested length, and normal (1) otherwise.
- R6: For a non-prefetchable request completing normally, `resp` is disconnect (2) when the requested length exceeds 1, and normal (1) when it is 1.
- R7: For a target disconnect with data, `resp` is disconnect (2) if `att_xfer` < requested length, and normal (1) otherwise, whatever the value of `req_pref`.
- R8: A target abort (`att_term` = 4) ends the request with `resp` = 3, whatever the value of `att_xfer`. `tgt_rx_tabort` and `ini_tx_tabort` pulse together with `done`.
- R9: A master abort (`att_term` = 3) ends the request with `resp` = 4. `tgt_rx_mabort` pulses with `done`, and the target-abort pulses stay low.
- R10: After `MAX_TRIES` consecutive attempts that did not end the request, the last one raises no `reinit`. Instead, `done` and `timeout` pulse together with `resp` = 5 (no data).
- R11: `req_valid` has no effect while `busy`. `att_done` has no effect while idle or in the cycle in which `reinit` is high.
- R12: `resp` changes only in a cycle where `done` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New delayed read request strobe |
| req_len | input | LEN_W | Requested number of data phases |
| req_pref | input | 1 | Target address space is prefetchable |
| att_done | input | 1 | Current attempt has ended |
| att_term | input | 3 | Attempt termination: 0 normal, 1 retry, 2 disconnect, 3 master abort, 4 target abort |
| att_xfer | input | LEN_W | Data phases moved in the attempt |
| reinit | output | 1 | Start an attempt on the target bus |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Request finished; `resp` is valid |
| resp | output | 3 | Response for initiator: 0 none, 1 normal, 2 disconnect, 3 target abort, 4 master abort, 5 no data |
| timeout | output | 1 | Attempt limit reached |
| tgt_rx_tabort | output | 1 | Set pulse, target-side received target abort |
| tgt_rx_mabort | output | 1 | Set pulse, target-side received master abort |
| ini_tx_tabort | output | 1 | Set pulse, initiator-side signaled target abort |

## Verification
The properties assume two things about the inputs. `att_term` carries only the five defined codes whenever `att_done` is high. The target-side master reports each attempt once, after the `reinit` that started it. The stimulus drives `att_done` one cycle after each `reinit` is seen, and holds it for exactly one cycle. Only stray strobes used to exercise R11 are driven outside that window, and they are placed where the design must ignore them. The attempt limit is lowered to 8 so that exhaustion falls well inside the run.

// File: rtl/dr_pkg.sv
package dr_pkg;

   typedef enum logic [2:0] {
      ATT_NORMAL = 3'd0,
      ATT_RETRY  = 3'd1,
      ATT_DISC   = 3'd2,
      ATT_MABORT = 3'd3,
      ATT_TABORT = 3'd4
   } att_term_e;

   typedef enum logic [2:0] {
      RSP_NONE   = 3'd0,
      RSP_NORMAL = 3'd1,
      RSP_DISC   = 3'd2,
      RSP_TABORT = 3'd3,
      RSP_MABORT = 3'd4,
      RSP_NODATA = 3'd5
   } resp_e;

endpackage

// File: rtl/dr_attempt_cnt.sv
// Counts fruitless attempts of the current request and flags the final allowed one.
module dr_attempt_cnt #(
   parameter int MAX_TRIES = 1 << 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic last
);
   localparam int CNT_W  = (MAX_TRIES > 2) ? $clog2(MAX_TRIES) : 1;
   localparam bit POW2   = (MAX_TRIES & (MAX_TRIES - 1)) == 0;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (bump)       cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (POW2) begin : g_pow2
         // Final try when every counter bit is set.
         assign last = &cnt_q;
      end else begin : g_cmp
         assign last = (cnt_q == CNT_W'(MAX_TRIES - 1));
      end
   endgenerate

endmodule

// File: rtl/dr_resp_sel.sv
// Classifies one attempt outcome and chooses the initiator response.
module dr_resp_sel
   import dr_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic [2:0]       term,
   input  logic [LEN_W-1:0] xfer,
   input  logic [LEN_W-1:0] len,
   input  logic             pref,
   output logic             again,
   output resp_e            code,
   output logic             tabort,
   output logic             mabort
);
   logic got_data;
   logic short_rd;

   assign got_data = (xfer != '0);
   assign short_rd = (xfer < len);

   always_comb begin
      again  = 1'b0;
      code   = RSP_NONE;
      tabort = 1'b0;
      mabort = 1'b0;
      case (att_term_e'(term))
         ATT_TABORT: begin
            code   = RSP_TABORT;
            tabort = 1'b1;
         end
         ATT_MABORT: begin
            code   = RSP_MABORT;
            mabort = 1'b1;
         end
         ATT_DISC: begin
            if (!got_data)     again = 1'b1;
            else if (short_rd) code  = RSP_DISC;
            else               code  = RSP_NORMAL;
         end
         ATT_NORMAL: begin
            if (!got_data)      again = 1'b1;
            else if (pref)      code  = short_rd ? RSP_DISC : RSP_NORMAL;
            else if (len > LEN_W'(1)) code = RSP_DISC;
            else                code  = RSP_NORMAL;
         end
         default: again = 1'b1;
      endcase
   end

endmodule

// File: rtl/dr_retry_ctrl.sv
module dr_retry_ctrl
   import dr_pkg::*;
#(
   parameter int LEN_W     = 8,
   parameter int MAX_TRIES = 1 << 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_pref,
   input  logic             att_done,
   input  logic [2:0]       att_term,
   input  logic [LEN_W-1:0] att_xfer,
   output logic             reinit,
   output logic             busy,
   output logic             done,
   output logic [2:0]       resp,
   output logic             timeout,
   output logic             tgt_rx_tabort,
   output logic             tgt_rx_mabort,
   output logic             ini_tx_tabort
);

   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("dr_retry_ctrl: LEN_W must be at least 1");
      end
      if (MAX_TRIES < 2) begin : g_bad_tries
         $error("dr_retry_ctrl: MAX_TRIES must be at least 2");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

   st_e              st_q;
   logic [LEN_W-1:0] len_q;
   logic             pref_q;
   logic             again;
   resp_e            code;
   logic             sel_tab, sel_mab;
   logic             last_try;
   logic             accept, judge, fruitless, finish_data, finish_out;
   resp_e            resp_q;

   dr_resp_sel #(.LEN_W(LEN_W)) u_sel (
      .term   (att_term),
      .xfer   (att_xfer),
      .len    (len_q),
      .pref   (pref_q),
      .again  (again),
      .code   (code),
      .tabort (sel_tab),
      .mabort (sel_mab)
   );

   assign accept      = (st_q == ST_IDLE) && req_valid;
   assign judge       = (st_q == ST_WAIT) && att_done;
   assign fruitless   = judge && again;
   assign finish_data = judge && !again;
   assign finish_out  = fruitless && last_try;

   dr_attempt_cnt #(.MAX_TRIES(MAX_TRIES)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .bump  (fruitless),
      .last  (last_try)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q  <= '0;
         pref_q <= 1'b0;
      end else if (accept) begin
         len_q  <= req_len;
         pref_q <= req_pref;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE:  if (req_valid) st_q <= ST_ISSUE;
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (finish_data || finish_out) st_q <= ST_IDLE;
               else if (fruitless)            st_q <= ST_ISSUE;
            end
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done          <= 1'b0;
         timeout       <= 1'b0;
         tgt_rx_tabort <= 1'b0;
         tgt_rx_mabort <= 1'b0;
         ini_tx_tabort <= 1'b0;
         resp_q        <= RSP_NONE;
      end else begin
         done          <= finish_data || finish_out;
         timeout       <= finish_out;
         tgt_rx_tabort <= finish_data && sel_tab;
         ini_tx_tabort <= finish_data && sel_tab;
         tgt_rx_mabort <= finish_data && sel_mab;
         if (finish_out)       resp_q <= RSP_NODATA;
         else if (finish_data) resp_q <= code;
      end
   end

   assign reinit = (st_q == ST_ISSUE);
   assign busy   = (st_q != ST_IDLE);
   assign resp   = resp_q;

endmodule

// File: rtl/dr_retry_ctrl_chk.sv
module dr_retry_ctrl_chk #(
   parameter int LEN_W     = 8,
   parameter int MAX_TRIES = 1 << 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [LEN_W-1:0] req_len,
   input logic             req_pref,
   input logic             att_done,
   input logic [2:0]       att_term,
   input logic [LEN_W-1:0] att_xfer,
   input logic             reinit,
   input logic             busy,
   input logic             done,
   input logic [2:0]       resp,
   input logic             timeout,
   input logic             tgt_rx_tabort,
   input logic             tgt_rx_mabort,
   input logic             ini_tx_tabort
);
   // Attempts started since the current request was accepted.
   int unsigned tries_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)                  tries_seen <= 0;
      else if (!busy && req_valid) tries_seen <= 0;
      else if (reinit)             tries_seen <= tries_seen + 1;
   end

   a_r2_reinit_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (reinit && busy));

   a_r2_reinit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> !reinit);

   a_r3_retry_reissues: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !reinit && att_done && att_term == 3'd1) |=> (reinit || (done && timeout)));

   a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_tabort_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp == 3'd3) |-> (tgt_rx_tabort && ini_tx_tabort));

   a_r8_tabort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rx_tabort || ini_tx_tabort) |-> (done && resp == 3'd3));

   a_r9_mabort_only: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rx_mabort |-> (done && resp == 3'd4 && !tgt_rx_tabort && !ini_tx_tabort));

   a_r10_timeout_nodata: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (done && resp == 3'd5 && !reinit));

   a_r10_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |-> (tries_seen < MAX_TRIES));

   a_r12_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(resp));

endmodule

bind dr_retry_ctrl dr_retry_ctrl_chk #(.LEN_W(LEN_W), .MAX_TRIES(MAX_TRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
   .req_pref(req_pref), .att_done(att_done), .att_term(att_term),
   .att_xfer(att_xfer), .reinit(reinit), .busy(busy), .done(done),
   .resp(resp), .timeout(timeout), .tgt_rx_tabort(tgt_rx_tabort),
   .tgt_rx_mabort(tgt_rx_mabort), .ini_tx_tabort(ini_tx_tabort)
);

// File: tb/dr_retry_ctrl_tb_top.sv
`timescale 1ns/1ps
module dr_retry_ctrl_tb_top;
   localparam int LW = 8;
   localparam int MT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [LW-1:0] req_len = '0;
   logic req_pref = 1'b0;
   logic att_done = 1'b0;
   logic [2:0] att_term = '0;
   logic [LW-1:0] att_xfer = '0;
   logic reinit, busy, done, timeout, tgt_rx_tabort, tgt_rx_mabort, ini_tx_tabort;
   logic [2:0] resp;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dr_retry_ctrl #(.LEN_W(LW), .MAX_TRIES(MT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
      .req_pref(req_pref), .att_done(att_done), .att_term(att_term),
      .att_xfer(att_xfer), .reinit(reinit), .busy(busy), .done(done),
      .resp(resp), .timeout(timeout), .tgt_rx_tabort(tgt_rx_tabort),
      .tgt_rx_mabort(tgt_rx_mabort), .ini_tx_tabort(ini_tx_tabort)
   );

   // Behavioural reference model
   int m_st = 0;          // 0 idle, 1 issuing, 2 waiting
   int m_len = 0;
   int m_pref = 0;
   int m_tries = 0;
   int m_done = 0, m_resp = 0, m_to = 0, m_rta = 0, m_rma = 0, m_sta = 0;
   string m_tag = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_tries = 0; m_done = 0; m_resp = 0; m_to = 0;
         m_rta = 0; m_rma = 0; m_sta = 0; m_tag = "R1";
      end else begin
         m_done = 0; m_to = 0; m_rta = 0; m_rma = 0; m_sta = 0;
         if (m_st != 0 && req_valid) m_tag = "R11";
         if (m_st != 2 && att_done)  m_tag = "R11";
         case (m_st)
            0: if (req_valid) begin
                  m_len = int'(req_len); m_pref = int'(req_pref);
                  m_tries = 0; m_st = 1; m_tag = "R2";
               end
            1: m_st = 2;
            default: if (att_done) begin
               if (att_term == 3'd4) begin
                  m_done = 1; m_resp = 3; m_rta = 1; m_sta = 1; m_st = 0; m_tag = "R8";
               end else if (att_term == 3'd3) begin
                  m_done = 1; m_resp = 4; m_rma = 1; m_st = 0; m_tag = "R9";
               end else if ((att_term == 3'd0 || att_term == 3'd2) && att_xfer != 0) begin
                  m_done = 1; m_st = 0;
                  if (att_term == 3'd2) begin
                     m_resp = (int'(att_xfer) < m_len) ? 2 : 1; m_tag = "R7";
                  end else if (m_pref != 0) begin
                     m_resp = (int'(att_xfer) < m_len) ? 2 : 1; m_tag = "R5";
                  end else begin
                     m_resp = (m_len > 1) ? 2 : 1; m_tag = "R6";
                  end
               end else begin
                  m_tries++;
                  if (m_tries == MT) begin
                     m_done = 1; m_resp = 5; m_to = 1; m_st = 0; m_tag = "R10";
                  end else begin
                     m_st = 1; m_tag = "R3";
                  end
               end
            end
         endcase
      end
   end

   task automatic cmp(string tag, string sig, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, sig, act, exp);
      end
   endtask

   // Compare every output against the model once per clock, away from the edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         cmp(m_tag, "reinit", int'(reinit), (m_st == 1) ? 1 : 0);
         cmp(m_tag, "busy", int'(busy), (m_st != 0) ? 1 : 0);
         cmp(m_tag == "R3" ? "R4" : m_tag, "done", int'(done), m_done);
         cmp(m_done != 0 ? m_tag : "R12", "resp", int'(resp), m_resp);
         cmp(m_tag, "timeout", int'(timeout), m_to);
         cmp(m_tag, "tgt_rx_tabort", int'(tgt_rx_tabort), m_rta);
         cmp(m_tag, "tgt_rx_mabort", int'(tgt_rx_mabort), m_rma);
         cmp(m_tag, "ini_tx_tabort", int'(ini_tx_tabort), m_sta);
      end
   end

   task automatic gap(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic request(int len, bit pref);
      @(negedge clk);
      req_valid = 1'b1; req_len = LW'(len); req_pref = pref;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic attempt(int term, int xfer);
      while (!reinit) @(negedge clk);
      @(negedge clk);
      att_done = 1'b1; att_term = 3'(term); att_xfer = LW'(xfer);
      @(negedge clk);
      att_done = 1'b0;
   endtask

   // Called right after the attempt that must end the request.
   task automatic expect_end(string tag, int code);
      cmp(tag, "end done", int'(done), 1);
      cmp(tag, "end resp", int'(resp), code);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
   end

   initial begin
      gap(3);
      // R1: outputs quiet during reset
      cmp("R1", "reset reinit", int'(reinit), 0);
      cmp("R1", "reset busy", int'(busy), 0);
      cmp("R1", "reset done", int'(done), 0);
      cmp("R1", "reset resp", int'(resp), 0);
      cmp("R1", "reset timeout", int'(timeout), 0);
      rst_n = 1'b1;
      gap(2);
      cmp("R1", "post-reset busy", int'(busy), 0);

      // R11: stray completion while idle
      att_done = 1'b1; att_term = 3'd0; att_xfer = 8'd3;
      @(negedge clk); att_done = 1'b0;
      gap(2);
      cmp("R11", "idle att_done ignored", int'(done), 0);

      // R5: prefetchable, full and short reads
      request(4, 1'b1); attempt(0, 4); expect_end("R5", 1); gap(2);
      request(4, 1'b1); attempt(0, 2); expect_end("R5", 2); gap(2);

      // R6: non-prefetchable
      request(4, 1'b0); attempt(0, 1); expect_end("R6", 2); gap(2);
      request(1, 1'b0); attempt(0, 1); expect_end("R6", 1); gap(2);

      // R7: target disconnect with data
      request(8, 1'b0); attempt(2, 3); expect_end("R7", 2); gap(2);
      request(8, 1'b1); attempt(2, 8); expect_end("R7", 1); gap(2);

      // R3 / R4: retries, then a zero-data disconnect, then data
      request(6, 1'b1);
      attempt(1, 0); attempt(1, 0); attempt(2, 0); attempt(0, 0);
      cmp("R3", "no done during retries", int'(done), 0);
      attempt(0, 6); expect_end("R4", 1); gap(2);

      // R8: target abort after partial data
      request(5, 1'b1); attempt(1, 0); attempt(4, 2); expect_end("R8", 3);
      cmp("R8", "rx tabort", int'(tgt_rx_tabort), 1);
      cmp("R8", "tx tabort", int'(ini_tx_tabort), 1);
      gap(2);

      // R9: master abort
      request(3, 1'b0); attempt(3, 0); expect_end("R9", 4);
      cmp("R9", "rx mabort", int'(tgt_rx_mabort), 1);
      gap(3);
      cmp("R12", "resp held", int'(resp), 4);

      // R10: exhaustion after MT fruitless attempts
      request(2, 1'b1);
      for (int i = 0; i < MT; i++) attempt(1, 0);
      expect_end("R10", 5);
      cmp("R10", "timeout", int'(timeout), 1);
      gap(2);

      // R11: second request and early completion while busy
      request(4, 1'b1);
      att_done = 1'b1; att_term = 3'd0; att_xfer = 8'd4;
      req_valid = 1'b1; req_len = 8'd1; req_pref = 1'b0;
      @(negedge clk);
      att_done = 1'b0; req_valid = 1'b0;
      cmp("R11", "done after early att_done", int'(done), 0);
      att_done = 1'b1; att_term = 3'd0; att_xfer = 8'd1;
      @(negedge clk); att_done = 1'b0;
      expect_end("R11", 2);   // original length 4 and prefetchable kept
      gap(4);
      summary();
   end

endmodule